// File: doc/BRIEF.md
# Processor Status Register

This block is the status register of a small 8-bit accumulator processor. It holds three arithmetic flags (zero, digit carry, carry), two power-state bits (time-out and power-down) and three bank-select bits. It is updated in three ways: by a data write when the register is the destination of an instruction, by flag results from the ALU, and by single-cycle event pulses for watchdog clear, sleep and watchdog time-out. Synchronous reset stands for power-on.

When an instruction both writes the register and updates flags, the ALU wins for all three flag positions: the written flag data is discarded, flags the instruction affects take the ALU value, and the other flags keep their value. The power-state bits never take written data. The decoder signals a write with no flag update by driving an all-zero flag mask, in which case every writable bit takes the written data. The two direct-addressing bank bits and the indirect half-select bit are brought out separately for the address logic.

Bit layout, most significant first: [7] indirect half select, [6:5] direct bank select, [4] time-out (TO), [3] power-down (PD), [2] Z, [1] DC, [0] C.

Top module: `psr_status_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, bits [7:5] clear, TO and PD set, and Z/DC/C load `FLAG_RST_VAL` (default 0), so the default reset value is 8'h18.
- R2: A write (`wr_en`=1) with `flag_upd`=3'b000 loads bits [7:5] and [2:0] from `wr_data` on the next edge.
- R3: Bits [4:3] never take written data; without an event pulse they hold their value through any write or flag update.
- R4: Without a write, each flag whose `flag_upd` bit is 1 (bit 2=Z, 1=DC, 0=C) loads the matching `alu_flags` bit; flags whose bit is 0 hold.
- R5: With a write and a nonzero `flag_upd`, bits [2:0] ignore `wr_data`: selected flags load `alu_flags`, unselected ones hold, while bits [7:5] still load `wr_data` (a clear aimed at the register with only Z selected gives 000uu1uu).
- R6: `ev_clrwdt` sets TO and PD.
- R7: `ev_sleep` sets TO and clears PD.
- R8: `ev_wdt_to` clears TO and leaves PD alone; when it coincides with `ev_clrwdt`, TO is cleared.
- R9: `bank_sel` always equals bits [6:5] of `stat_q` and `ind_hi` equals bit 7.
- R10: When `ev_sleep` and `ev_clrwdt` coincide, PD is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Register is this instruction's write destination |
| wr_data | input | 8 | Data written by the instruction |
| flag_upd | input | 3 | Flags the instruction updates ({Z,DC,C}) |
| alu_flags | input | 3 | Flag values from the ALU ({Z,DC,C}) |
| ev_clrwdt | input | 1 | Watchdog-clear instruction pulse |
| ev_sleep | input | 1 | Sleep instruction pulse |
| ev_wdt_to | input | 1 | Watchdog time-out pulse |
| stat_q | output | 8 | Current register value |
| bank_sel | output | 2 | Direct-addressing bank select |
| ind_hi | output | 1 | Indirect-addressing half select |

## Verification
Every stored bit is visible on `stat_q` one edge after the update that sets it, so a wrong merge between written data, ALU flags and events shows as a bad bit on the very next sample. A wrong hold is subtler: a flag that should have been blocked or kept shows only if the bench first drives it to the opposite value, so each conflict scenario preloads flags with values that differ from the data written. Errors in the power bits appear only after a write or event sequence that would touch them, which the event scenarios walk through in order, including coincident pulses.

// File: rtl/psr_pkg.sv
// Package: bit positions and shared types of the status register.
// Assumes the 8-bit layout {ind_hi, bank[1:0], to, pd, z, dc, c}.
package psr_pkg;
    localparam int STAT_W   = 8;
    localparam int FLAG_W   = 3;
    localparam int BANK_W   = 3;
    localparam int POS_C    = 0;
    localparam int POS_DC   = 1;
    localparam int POS_Z    = 2;
    localparam int POS_PD   = 3;
    localparam int POS_TO   = 4;
    localparam int POS_BANK = 5;

    typedef logic [FLAG_W-1:0] flag_vec_t;
    typedef logic [BANK_W-1:0] bank_vec_t;
endpackage

// File: rtl/psr_flag_slice.sv
// Flag slice: holds Z, DC, C. ALU results take priority over written data;
// any nonzero update mask blocks the data write to all three flags.
// Assumes upd_mask/alu_flags/wr_flags share the order {Z,DC,C}.
module psr_flag_slice
    import psr_pkg::*;
#(
    parameter flag_vec_t RST_VAL = '0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  flag_vec_t wr_flags,
    input  flag_vec_t upd_mask,
    input  flag_vec_t alu_flags,
    output flag_vec_t flags_q
);
    logic data_ok;

    // Data reaches the flags only on a write that updates no flag.
    assign data_ok = wr_en && (upd_mask == '0);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        // Per-flag register with ALU-over-data-over-hold priority.
        always_ff @(posedge clk) begin
            if (!rst_n)            flags_q[i] <= RST_VAL[i];
            else if (upd_mask[i])  flags_q[i] <= alu_flags[i];
            else if (data_ok)      flags_q[i] <= wr_flags[i];
        end

        a_r4_alu_loads_flag: assert property (@(posedge clk) disable iff (!rst_n)
            upd_mask[i] |=> flags_q[i] == $past(alu_flags[i]));

        a_r5_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (upd_mask != '0) && !upd_mask[i]) |=> $stable(flags_q[i]));
    end
endmodule

// File: rtl/psr_bank_slice.sv
// Bank slice: holds the indirect half select and the two direct bank bits.
// Loaded by any write; flag updates and events never touch it.
module psr_bank_slice
    import psr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  bank_vec_t wr_bank,
    output bank_vec_t bank_q
);
    // Bank bits clear on reset and follow written data.
    always_ff @(posedge clk) begin
        if (!rst_n)     bank_q <= '0;
        else if (wr_en) bank_q <= wr_bank;
    end

    a_r2_bank_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bank_q == $past(wr_bank));

    a_r2_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bank_q));
endmodule

// File: rtl/psr_power_slice.sv
// Power slice: time-out and power-down bits. Changed only by events:
// time-out beats watchdog clear for TO, sleep beats watchdog clear for PD.
// Assumes each event is a single-cycle pulse from the control logic.
module psr_power_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_clrwdt,
    input  logic ev_sleep,
    input  logic ev_wdt_to,
    output logic to_q,
    output logic pd_q
);
    // TO: set on power-up, clear or sleep; cleared by time-out.
    always_ff @(posedge clk) begin
        if (!rst_n)                     to_q <= 1'b1;
        else if (ev_wdt_to)             to_q <= 1'b0;
        else if (ev_clrwdt || ev_sleep) to_q <= 1'b1;
    end

    // PD: set on power-up or clear; cleared by sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)         pd_q <= 1'b1;
        else if (ev_sleep)  pd_q <= 1'b0;
        else if (ev_clrwdt) pd_q <= 1'b1;
    end

    a_r3_power_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_clrwdt || ev_sleep || ev_wdt_to) |=> $stable({to_q, pd_q}));

    a_r6_clrwdt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_clrwdt && !ev_sleep && !ev_wdt_to) |=> (to_q && pd_q));

    a_r7_sleep_state: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !ev_wdt_to) |=> (to_q && !pd_q));

    a_r8_timeout_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_to |=> !to_q);

    a_r10_sleep_wins_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && ev_clrwdt) |=> !pd_q);
endmodule

// File: rtl/psr_status_reg.sv
// Status register top: splits the written byte among the bank, power and
// flag slices and reassembles the stored value. Assumes the decoder gives
// flag_upd = 0 for writes that must not touch flags.
module psr_status_reg
    import psr_pkg::*;
#(
    parameter logic [FLAG_W-1:0] FLAG_RST_VAL = 3'b000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] flag_upd,
    input  logic [FLAG_W-1:0] alu_flags,
    input  logic              ev_clrwdt,
    input  logic              ev_sleep,
    input  logic              ev_wdt_to,
    output logic [STAT_W-1:0] stat_q,
    output logic [1:0]        bank_sel,
    output logic              ind_hi
);
    bank_vec_t bank_q;
    flag_vec_t flags_q;
    logic      to_q;
    logic      pd_q;

    psr_bank_slice u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bank (wr_data[STAT_W-1:POS_BANK]),
        .bank_q  (bank_q)
    );

    psr_power_slice u_power (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_clrwdt (ev_clrwdt),
        .ev_sleep  (ev_sleep),
        .ev_wdt_to (ev_wdt_to),
        .to_q      (to_q),
        .pd_q      (pd_q)
    );

    psr_flag_slice #(.RST_VAL(FLAG_RST_VAL)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_flags  (wr_data[POS_Z:POS_C]),
        .upd_mask  (flag_upd),
        .alu_flags (alu_flags),
        .flags_q   (flags_q)
    );

    // Reassemble the byte and expose the address-select fields.
    always_comb begin
        stat_q   = {bank_q, to_q, pd_q, flags_q};
        bank_sel = bank_q[1:0];
        ind_hi   = bank_q[2];
    end

    a_r1_reset_value: assert property (@(posedge clk)
        !rst_n |=> stat_q == {3'b000, 2'b11, FLAG_RST_VAL});

    a_r3_power_ignores_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !ev_clrwdt && !ev_sleep && !ev_wdt_to) |=> $stable(stat_q[POS_TO:POS_PD]));
endmodule

// File: tb/psr_status_reg_tb.sv
`timescale 1ns/100ps
// Directed bench for the status register: one task per scenario.
module psr_status_reg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [2:0] flag_upd;
    logic [2:0] alu_flags;
    logic       ev_clrwdt, ev_sleep, ev_wdt_to;
    logic [7:0] stat_q;
    logic [1:0] bank_sel;
    logic       ind_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    psr_status_reg dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .flag_upd(flag_upd), .alu_flags(alu_flags), .ev_clrwdt(ev_clrwdt),
        .ev_sleep(ev_sleep), .ev_wdt_to(ev_wdt_to), .stat_q(stat_q),
        .bank_sel(bank_sel), .ind_hi(ind_hi)
    );

    task automatic check(string req, logic [7:0] got, logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_data = '0; flag_upd = '0; alu_flags = '0;
        ev_clrwdt = 0; ev_sleep = 0; ev_wdt_to = 0;
    endtask

    // One clock with the given stimulus; inputs return to idle afterwards.
    task automatic step(logic w, logic [7:0] d, logic [2:0] u, logic [2:0] a,
                        logic clr, logic slp, logic tmo);
        wr_en = w; wr_data = d; flag_upd = u; alu_flags = a;
        ev_clrwdt = clr; ev_sleep = slp; ev_wdt_to = tmo;
        @(posedge clk); #1;
        idle();
    endtask

    task automatic t_reset();
        rst_n = 0; idle();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset value", stat_q, 8'h18);
        check("R9 bank after reset", {6'b0, bank_sel}, 8'h00);
        rst_n = 1;
    endtask

    task automatic t_write();
        step(1, 8'hFF, 3'b000, 3'b000, 0, 0, 0);
        check("R2 write all ones", stat_q, 8'hFF);
        step(1, 8'h00, 3'b000, 3'b000, 0, 0, 0);
        check("R3 TO/PD keep 1 on zero write", stat_q, 8'h18);
        step(1, 8'h40, 3'b000, 3'b000, 0, 0, 0);
        check("R2 write 40", stat_q, 8'h58);
        check("R9 bank_sel 10", {6'b0, bank_sel}, 8'h02);
        step(1, 8'hA0, 3'b000, 3'b000, 0, 0, 0);
        check("R9 bank_sel 01", {6'b0, bank_sel}, 8'h01);
        check("R9 ind_hi", {7'b0, ind_hi}, 8'h01);
        check("R2 write A0", stat_q, 8'hB8);
    endtask

    task automatic t_alu();
        step(0, 8'h00, 3'b101, 3'b111, 0, 0, 0);
        check("R4 Z and C load, DC holds", stat_q, 8'hBD);
        step(0, 8'h00, 3'b010, 3'b010, 0, 0, 0);
        check("R4 DC load", stat_q, 8'hBF);
        step(0, 8'h00, 3'b111, 3'b000, 0, 0, 0);
        check("R4 all flags clear", stat_q, 8'hB8);
    endtask

    task automatic t_conflict();
        step(0, 8'h00, 3'b111, 3'b011, 0, 0, 0);
        check("R4 preload DC C", stat_q, 8'hBB);
        step(1, 8'h00, 3'b100, 3'b100, 0, 0, 0);
        check("R5 clear gives 000uu1uu", stat_q, 8'h1F);
        step(1, 8'hFF, 3'b001, 3'b000, 0, 0, 0);
        check("R5 data blocked, C from ALU", stat_q, 8'hFE);
    endtask

    task automatic t_events();
        step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0);
        check("R7 sleep", stat_q, 8'hF6);
        step(0, 8'h00, 3'b000, 3'b000, 1, 0, 0);
        check("R6 clrwdt", stat_q, 8'hFE);
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 1);
        check("R8 time-out", stat_q, 8'hEE);
        step(1, 8'h18, 3'b000, 3'b000, 0, 0, 0);
        check("R3 write ignored on TO/PD", stat_q, 8'h08);
        step(0, 8'h00, 3'b000, 3'b000, 1, 0, 1);
        check("R8 time-out beats clrwdt", stat_q, 8'h08);
        step(0, 8'h00, 3'b000, 3'b000, 1, 0, 0);
        check("R6 clrwdt restores", stat_q, 8'h18);
        step(0, 8'h00, 3'b000, 3'b000, 1, 1, 0);
        check("R10 sleep beats clrwdt", stat_q, 8'h10);
        step(0, 8'h00, 3'b000, 3'b000, 0, 1, 1);
        check("R8 time-out with sleep", stat_q, 8'h00);
    endtask

    initial begin
        rst_n = 0; idle();
        @(negedge clk);
        t_reset();
        t_write();
        t_alu();
        t_conflict();
        t_events();
        @(negedge clk);
        t_reset();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule